// File: doc/BRIEF.md
# NAND Page ECC Syndrome Checker and Single-Bit Corrector

This block judges the 22-bit Hamming-style check code that guards one 256-byte chunk of a NAND page. It takes the code recomputed while the chunk streamed in and the code read back from the spare area. Their XOR forms the syndrome. From it the block decides one of four outcomes: the data is clean, only the stored code is damaged, one data bit is wrong and can be repaired, or the damage cannot be repaired. For a repairable error it reports the byte and bit that failed. A combinational read-modify port lets the page buffer pass any byte through the block and get it back with the faulty bit flipped.

In double-chunk mode the block judges a second pair of codes for bytes 256 to 511 in the following cycle. It sets one combined failure flag when either chunk has a code-only error or an unrepairable error. A four-state machine sequences the work. `IDLE` accepts a start pulse and latches the codes and the mode (transition *accept*). `SCAN_LO` registers the verdict for the first chunk, then goes to `SCAN_HI` in double-chunk mode (transition *extend*) or straight to `REPORT` (transition *finish_single*). `SCAN_HI` registers the second verdict and moves to `REPORT` (transition *finish_double*). `REPORT` raises `done` for one cycle and returns to `IDLE` (transition *release*).

Top module: `nand_ecc_fixer`

## Requirements
- R1: After reset, both chunk statuses are 0, all byte and bit indices are 0, and `done`, `fail` and `busy` are 0.
- R2: A `start` sampled while `busy` is low is accepted. `done` is high in the second cycle after the accepting edge in single-chunk mode and in the third in double-chunk mode. `busy` is high from the accepting edge until `done` falls.
- R3: A chunk whose syndrome is zero, or whose computed or stored code is all zero, gets status 0 (clean) and no correction.
- R4: A chunk whose syndrome has exactly one bit set gets status 2 (code-only error). It raises `fail` and gets no correction.
- R5: A chunk gets status 1 (corrected) when its syndrome has exactly 11 bits set and the XOR of syndrome bits 10:0 with bits 21:11 is all ones. Its bit index is then syndrome bits 2:0 and its byte index is syndrome bits 10:3. `fail` stays low for it.
- R6: Any other syndrome gives status 3 (uncorrectable) and raises `fail`.
- R7: The byte and bit indices of a chunk are 0 whenever its status is not 1.
- R8: `rmw_addr[8]` selects the chunk and `rmw_addr[7:0]` the byte. When the selected chunk has status 1 and the byte matches its byte index, `rmw_out` equals `rmw_in` XOR (1 << bit index). Otherwise `rmw_out` equals `rmw_in`.
- R9: In double-chunk mode the second chunk is judged from `calc_hi`/`stored_hi`, and `fail` is the OR of both chunks' failures. In single-chunk mode the second status stays 0.
- R10: A `start` that arrives while `busy` is high is ignored. The run in progress keeps its codes, and no extra run follows.
- R11: `done` is a single-cycle pulse. Results hold from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a judgement (pulse) |
| wide | input | 1 | 1 = two chunks (512 bytes), 0 = one chunk |
| calc_lo | input | 22 | Recomputed code, chunk 0 |
| stored_lo | input | 22 | Code read from flash, chunk 0 |
| calc_hi | input | 22 | Recomputed code, chunk 1 |
| stored_hi | input | 22 | Code read from flash, chunk 1 |
| rmw_addr | input | 9 | Chunk select (bit 8) and byte address |
| rmw_in | input | 8 | Byte read from the page buffer |
| rmw_out | output | 8 | Byte to write back, repaired if addressed |
| busy | output | 1 | Judgement in progress |
| done | output | 1 | Results valid pulse |
| fail | output | 1 | Code-only or uncorrectable error in any judged chunk |
| status_lo | output | 2 | Chunk 0 verdict: 0 clean, 1 corrected, 2 code-only, 3 uncorrectable |
| byte_lo | output | 8 | Chunk 0 failing byte |
| bit_lo | output | 3 | Chunk 0 failing bit |
| status_hi | output | 2 | Chunk 1 verdict, same coding |
| byte_hi | output | 8 | Chunk 1 failing byte |
| bit_hi | output | 3 | Chunk 1 failing bit |

## Verification
Two functions can land in the same report. A repair pending in one chunk can coincide with a failure verdict from the other, and a new start request can arrive while a judgement is still running. The bench runs double-chunk judgements that pair a repairable first chunk with an unrepairable second one, and the reverse. It then checks that `fail` is raised while the read-modify port still flips exactly the repaired byte in the correct half. It also pulses `start` with different codes during `SCAN_LO` and checks that the reported verdict and latency belong to the first request and that no second `done` follows.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    // Verdict coding seen on the status ports
    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_FIXED    = 2'd1,
        ST_ECC_ONLY = 2'd2,
        ST_BROKEN   = 2'd3
    } ecc_status_e;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_SCAN_LO = 2'd1,
        S_SCAN_HI = 2'd2,
        S_REPORT  = 2'd3
    } fixer_state_e;

endpackage

// File: rtl/ecc_classify.sv
module ecc_classify
    import nand_ecc_pkg::*;
#(
    parameter int CODE_W = 22
) (
    input  logic [CODE_W-1:0]   calc,
    input  logic [CODE_W-1:0]   stored,
    output ecc_status_e         verdict,
    output logic [CODE_W/2-1:0] loc
);
    localparam int HALF_W = CODE_W / 2;
    localparam int CNT_W  = $clog2(CODE_W + 1);

    logic [CODE_W-1:0] syn;
    logic [HALF_W-1:0] pair;
    logic [CNT_W-1:0]  ones;

    always_comb begin
        syn  = calc ^ stored;
        pair = syn[HALF_W-1:0] ^ syn[CODE_W-1:HALF_W];
        ones = '0;
        for (int i = 0; i < CODE_W; i++) begin
            ones = ones + CNT_W'(syn[i]);
        end
    end

    always_comb begin
        loc = '0;
        if (syn == '0 || calc == '0 || stored == '0) begin
            verdict = ST_CLEAN;
        end else if (ones == CNT_W'(1)) begin
            verdict = ST_ECC_ONLY;
        end else if (ones == CNT_W'(HALF_W) && pair == '1) begin
            verdict = ST_FIXED;
            loc     = syn[HALF_W-1:0];
        end else begin
            verdict = ST_BROKEN;
        end
    end

endmodule

// File: rtl/ecc_rmw_flip.sv
module ecc_rmw_flip #(
    parameter int CHUNKS = 2,
    parameter int BYTE_W = 8,
    parameter int DATA_W = 8
) (
    input  logic [$clog2(CHUNKS)-1:0]                 sel,
    input  logic [BYTE_W-1:0]                         addr_byte,
    input  logic [CHUNKS-1:0]                         fixed,
    input  logic [CHUNKS-1:0][BYTE_W-1:0]             byte_idx,
    input  logic [CHUNKS-1:0][$clog2(DATA_W)-1:0]     bit_idx,
    input  logic [DATA_W-1:0]                         din,
    output logic [DATA_W-1:0]                         dout
);
    localparam int SEL_W = $clog2(CHUNKS);

    logic [CHUNKS-1:0]             hit;
    logic [CHUNKS-1:0][DATA_W-1:0] mask;
    logic [DATA_W-1:0]             acc;

    for (genvar g = 0; g < CHUNKS; g++) begin : g_chunk
        assign hit[g]  = fixed[g] && (sel == SEL_W'(g)) && (addr_byte == byte_idx[g]);
        assign mask[g] = hit[g] ? (DATA_W'(1) << bit_idx[g]) : '0;
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < CHUNKS; k++) begin
            acc = acc | mask[k];
        end
        dout = din ^ acc;
    end

    // R8
    always_comb begin
        single_flip_chk: assert ($countones(dout ^ din) <= 1)
            else $error("more than one bit changed on the repair path");
    end

endmodule

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer
    import nand_ecc_pkg::*;
#(
    parameter int CODE_W = 22,
    parameter int DATA_W = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic                                   wide,
    input  logic [CODE_W-1:0]                      calc_lo,
    input  logic [CODE_W-1:0]                      stored_lo,
    input  logic [CODE_W-1:0]                      calc_hi,
    input  logic [CODE_W-1:0]                      stored_hi,
    input  logic [CODE_W/2-$clog2(DATA_W):0]       rmw_addr,
    input  logic [DATA_W-1:0]                      rmw_in,
    output logic [DATA_W-1:0]                      rmw_out,
    output logic                                   busy,
    output logic                                   done,
    output logic                                   fail,
    output logic [1:0]                             status_lo,
    output logic [CODE_W/2-$clog2(DATA_W)-1:0]     byte_lo,
    output logic [$clog2(DATA_W)-1:0]              bit_lo,
    output logic [1:0]                             status_hi,
    output logic [CODE_W/2-$clog2(DATA_W)-1:0]     byte_hi,
    output logic [$clog2(DATA_W)-1:0]              bit_hi
);
    localparam int CHUNKS = 2;
    localparam int HALF_W = CODE_W / 2;
    localparam int BIT_W  = $clog2(DATA_W);
    localparam int BYTE_W = HALF_W - BIT_W;

    fixer_state_e state, nxt;

    logic                          wide_q;
    logic [CHUNKS-1:0][CODE_W-1:0] calc_q;
    logic [CHUNKS-1:0][CODE_W-1:0] stored_q;
    ecc_status_e                   stat_q [CHUNKS];
    logic [CHUNKS-1:0][HALF_W-1:0] loc_q;
    logic                          fail_q;

    logic                          pick_hi;
    ecc_status_e                   cls_verdict;
    logic [HALF_W-1:0]             cls_loc;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start) nxt = S_SCAN_LO;
            S_SCAN_LO: nxt = wide_q ? S_SCAN_HI : S_REPORT;
            S_SCAN_HI: nxt = S_REPORT;
            S_REPORT:  nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // ---------------- shared classifier ----------------
    assign pick_hi = (state == S_SCAN_HI);

    ecc_classify #(.CODE_W(CODE_W)) u_cls (
        .calc    (pick_hi ? calc_q[1]   : calc_q[0]),
        .stored  (pick_hi ? stored_q[1] : stored_q[0]),
        .verdict (cls_verdict),
        .loc     (cls_loc)
    );

    // ---------------- result registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q   <= 1'b0;
            calc_q   <= '0;
            stored_q <= '0;
            loc_q    <= '0;
            fail_q   <= 1'b0;
            for (int k = 0; k < CHUNKS; k++) stat_q[k] <= ST_CLEAN;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        wide_q      <= wide;
                        calc_q[0]   <= calc_lo;
                        stored_q[0] <= stored_lo;
                        calc_q[1]   <= calc_hi;
                        stored_q[1] <= stored_hi;
                        loc_q       <= '0;
                        fail_q      <= 1'b0;
                        for (int k = 0; k < CHUNKS; k++) stat_q[k] <= ST_CLEAN;
                    end
                end
                S_SCAN_LO: begin
                    stat_q[0] <= cls_verdict;
                    loc_q[0]  <= cls_loc;
                    fail_q    <= fail_q | cls_verdict[1];
                end
                S_SCAN_HI: begin
                    stat_q[1] <= cls_verdict;
                    loc_q[1]  <= cls_loc;
                    fail_q    <= fail_q | cls_verdict[1];
                end
                S_REPORT: begin
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    logic [CHUNKS-1:0]             fixed_vec;
    logic [CHUNKS-1:0][BYTE_W-1:0] byte_pk;
    logic [CHUNKS-1:0][BIT_W-1:0]  bit_pk;

    for (genvar g = 0; g < CHUNKS; g++) begin : g_out
        assign fixed_vec[g] = (stat_q[g] == ST_FIXED);
        assign byte_pk[g]   = loc_q[g][HALF_W-1:BIT_W];
        assign bit_pk[g]    = loc_q[g][BIT_W-1:0];
    end

    assign busy      = (state != S_IDLE);
    assign done      = (state == S_REPORT);
    assign fail      = fail_q;
    assign status_lo = stat_q[0];
    assign status_hi = stat_q[1];
    assign byte_lo   = byte_pk[0];
    assign bit_lo    = bit_pk[0];
    assign byte_hi   = byte_pk[1];
    assign bit_hi    = bit_pk[1];

    ecc_rmw_flip #(.CHUNKS(CHUNKS), .BYTE_W(BYTE_W), .DATA_W(DATA_W)) u_flip (
        .sel       (rmw_addr[BYTE_W]),
        .addr_byte (rmw_addr[BYTE_W-1:0]),
        .fixed     (fixed_vec),
        .byte_idx  (byte_pk),
        .bit_idx   (bit_pk),
        .din       (rmw_in),
        .dout      (rmw_out)
    );

    // ---------------- assertions ----------------
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(calc_q) && $stable(stored_q) && $stable(wide_q)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_lo != 2'd1) |-> (byte_lo == '0 && bit_lo == '0));

    // R9
    narrow_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide_q) |-> (status_hi == 2'd0));

    // R9
    fail_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fail == (status_lo[1] | status_hi[1])));

endmodule

// File: tb/sim_nand_ecc_fixer.sv
module sim_nand_ecc_fixer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide = 1'b0;
    logic [21:0] calc_lo = '0, stored_lo = '0, calc_hi = '0, stored_hi = '0;
    logic [8:0]  rmw_addr = '0;
    logic [7:0]  rmw_in = '0;
    logic [7:0]  rmw_out;
    logic        busy, done, fail;
    logic [1:0]  status_lo, status_hi;
    logic [7:0]  byte_lo, byte_hi;
    logic [2:0]  bit_lo, bit_hi;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    nand_ecc_fixer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
        .calc_lo(calc_lo), .stored_lo(stored_lo), .calc_hi(calc_hi), .stored_hi(stored_hi),
        .rmw_addr(rmw_addr), .rmw_in(rmw_in), .rmw_out(rmw_out),
        .busy(busy), .done(done), .fail(fail),
        .status_lo(status_lo), .byte_lo(byte_lo), .bit_lo(bit_lo),
        .status_hi(status_hi), .byte_hi(byte_hi), .bit_hi(bit_hi)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected verdict from the requirement text: {status, loc}
    function automatic logic [12:0] model(input logic [21:0] c, input logic [21:0] s);
        logic [21:0] y;
        y = c ^ s;
        if (y == 0 || c == 0 || s == 0)                        return {2'd0, 11'd0}; // R3
        if ($countones(y) == 1)                                return {2'd2, 11'd0}; // R4
        if ($countones(y) == 11 && (y[10:0] ^ y[21:11]) == 11'h7FF)
                                                               return {2'd1, y[10:0]}; // R5
        return {2'd3, 11'd0};                                                        // R6
    endfunction

    // One judgement; checks latency (R2), verdicts, indices and fail.
    task automatic run(input logic w, input logic [21:0] c0, input logic [21:0] s0,
                       input logic [21:0] c1, input logic [21:0] s1);
        logic [12:0] e0, e1;
        int n;
        e0 = model(c0, s0);
        e1 = w ? model(c1, s1) : 13'd0;
        @(negedge clk);
        wide = w; calc_lo = c0; stored_lo = s0; calc_hi = c1; stored_hi = s1; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk(n == (w ? 3 : 2), "R2 latency", n, w ? 3 : 2);
        chk(status_lo == e0[12:11], "R3/R4/R5/R6 status_lo", status_lo, e0[12:11]);
        chk(status_hi == e1[12:11], "R9 status_hi", status_hi, e1[12:11]);
        chk({byte_lo, bit_lo} == e0[10:0], "R5/R7 loc_lo", {byte_lo, bit_lo}, e0[10:0]);
        chk({byte_hi, bit_hi} == e1[10:0], "R5/R7 loc_hi", {byte_hi, bit_hi}, e1[10:0]);
        chk(fail == (e0[12] | e1[12]), "R9 fail OR", fail, e0[12] | e1[12]);
        @(negedge clk);
        chk(!done && !busy, "R11 done single pulse", {done, busy}, 0);
        chk(status_lo == e0[12:11], "R11 result held", status_lo, e0[12:11]);
    endtask

    // Probe the repair port; expect a flip only where R8 says so.
    task automatic probe(input logic [8:0] a, input logic [7:0] d, input logic [7:0] exp);
        rmw_addr = a; rmw_in = d;
        #1;
        chk(rmw_out == exp, "R8 rmw", rmw_out, exp);
    endtask

    initial begin
        automatic logic [31:0] lf = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk({status_lo, status_hi, byte_lo, bit_lo, byte_hi, bit_hi} == 0, "R1 reset idx/status",
            {status_lo, status_hi, byte_lo, bit_lo, byte_hi, bit_hi}, 0);
        chk({done, fail, busy} == 0, "R1 reset flags", {done, fail, busy}, 0);
        rst_n = 1'b1;

        // R5/R8: sweep every repairable location, single chunk
        for (int loc = 0; loc < 2048; loc++) begin
            logic [21:0] c, s;
            logic [10:0] l;
            l = 11'(loc);
            c = 22'h2C3A5 ^ (22'(loc) << 7);
            s = c ^ {~l, l};
            run(1'b0, c, s, 22'h0, 22'h0);
            probe({1'b0, l[10:3]}, 8'hA5, 8'hA5 ^ (8'd1 << l[2:0]));        // R8 flip
            probe({1'b0, l[10:3] ^ 8'h01}, 8'h3C, 8'h3C);                   // R8 other byte
            probe({1'b1, l[10:3]}, 8'h5A, 8'h5A);                           // R9 hi half unused
        end

        // R4: every single-bit syndrome
        for (int b = 0; b < 22; b++) begin
            run(1'b0, 22'h15A5A, 22'h15A5A ^ (22'd1 << b), 22'h0, 22'h0);
            probe(9'h000, 8'hFF, 8'hFF);
        end

        // R3: zero-code and equal-code cases
        run(1'b0, 22'h0, 22'h3F00F, 22'h0, 22'h0);
        run(1'b0, 22'h2AAAA, 22'h0, 22'h0, 22'h0);
        run(1'b0, 22'h1C0DE, 22'h1C0DE, 22'h0, 22'h0);
        chk(status_lo == 2'd0 && !fail, "R3 equal codes clean", status_lo, 0);

        // R6: eleven bits set but a pair doubled
        run(1'b0, 22'h3FFFFF, 22'h3FFFFF ^ 22'h0803FF, 22'h0, 22'h0);
        chk(status_lo == 2'd3, "R6 paired eleven", status_lo, 3);
        run(1'b0, 22'h123456, 22'h123456 ^ 22'h000003, 22'h0, 22'h0);
        chk(status_lo == 2'd3, "R6 two bits", status_lo, 3);

        // R9: mixed verdicts in one double-chunk run
        run(1'b1, 22'h0F0F0F, 22'h0F0F0F ^ {~11'h135, 11'h135}, 22'h111111, 22'h111111 ^ 22'h000005);
        chk(status_lo == 2'd1 && status_hi == 2'd3 && fail, "R9 fixed+broken",
            {status_lo, status_hi, fail}, {2'd1, 2'd3, 1'b1});
        probe({1'b0, 8'h26}, 8'h00, 8'h20);
        probe({1'b1, 8'h26}, 8'h00, 8'h00);
        run(1'b1, 22'h222222, 22'h222222, 22'h0ABCDE, 22'h0ABCDE ^ {~11'h7F8, 11'h7F8});
        chk(status_hi == 2'd1 && !fail, "R9 clean+fixed", {status_hi, fail}, {2'd1, 1'b0});
        probe({1'b1, 8'hFF}, 8'h81, 8'h80);
        probe({1'b0, 8'hFF}, 8'h81, 8'h81);

        // R6/R9: pseudo-random double-chunk codes
        for (int t = 0; t < 400; t++) begin
            logic [21:0] a0, a1, a2, a3;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5); a0 = lf[21:0];
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5); a1 = lf[21:0];
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5); a2 = lf[21:0];
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5); a3 = lf[21:0];
            if (t[0]) a1 = a0 ^ (22'd1 << (t % 22));
            run(t[1], a0, a1, a2, a3);
        end

        // R10: start during SCAN_LO is ignored
        @(negedge clk);
        wide = 1'b0; calc_lo = 22'h3A3A3A; stored_lo = 22'h3A3A3A ^ {~11'h02D, 11'h02D};
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wide = 1'b1; calc_lo = 22'h100000; stored_lo = 22'h000003; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(done, "R10 original latency", done, 1);
        chk(status_lo == 2'd1 && byte_lo == 8'h05 && bit_lo == 3'd5, "R10 original codes kept",
            {status_lo, byte_lo, bit_lo}, {2'd1, 8'h05, 3'd5});
        chk(status_hi == 2'd0, "R10 original mode kept", status_hi, 0);
        @(negedge clk);
        @(negedge clk);
        chk(!busy && !done, "R10 no second run", {busy, done}, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule